// File: doc/BRIEF.md
# Distributed Shared-Bus Arbiter

Up to four agents share one external bus without any central arbiter. Every agent holds its own copy of this block. Each agent drives a single request line. Every copy watches all request lines and one shared lock line. All copies run the same decision on the same clock edge, so they always agree on who owns the bus. A copy raises `grant` only when its own agent is the owner.

A static mode input selects the priority scheme. In fixed mode the lowest agent index wins. In rotating mode the agent that gave up the bus most recently drops to the lowest priority. The owner can raise a lock so that nobody else can take the bus. A programmable hold limit takes the bus back from an owner that keeps it while other agents are waiting.

The control is a three-state machine, and every copy keeps it in the same state:
- `ST_EMPTY`: nobody has owned the bus since reset.
- `ST_HELD`: the owner is using the bus.
- `ST_PARK`: the last owner keeps the bus while nobody asks for it.

Its transitions are:
- **claim**: `ST_EMPTY` or `ST_PARK` to `ST_HELD` on any request.
- **release handover**: `ST_HELD` to `ST_HELD` with a new owner, when the owner drops its request and others are waiting.
- **timeout handover**: `ST_HELD` to `ST_HELD`, when the hold limit is reached and others are waiting.
- **park**: `ST_HELD` to `ST_PARK`, when the owner drops its request and nobody else is requesting.
- **lock hold**: any owned state stays where it is while the lock line is high.

Top module: `shared_bus_arbiter`

## Requirements
- R1: During and right after reset, no copy grants, `owner_id` is 0 and `tmo_flag` is low. The rotation pointer starts at agent N-1, so agent 0 comes first in rotating mode.
- R2: `req_drive` follows `loc_req` directly. `lock_drive` equals `loc_lock` while the copy holds `grant`, and is 0 otherwise.
- R3: With `rotate_mode`=0, a claim from `ST_EMPTY` or `ST_PARK` gives the bus to the requester with the lowest index. The grant appears on the first clock edge that samples the request.
- R4: With `rotate_mode`=1, candidates are searched upward, wrapping, starting one index above the agent that most recently released the bus or was preempted.
- R5: An owner that keeps requesting keeps the bus until its hold limit is reached.
- R6: When the owner drops its request, the lock line is low and other lines are requesting, ownership passes on that same edge to the winner among the other requesters.
- R7: When the owner drops its request and nobody else requests, the owner keeps `grant` (parking). Ownership is unchanged while all request lines stay low.
- R8: While `lock_line` is high, ownership does not change, whatever the request lines or the hold counter do. The hold counter stops while the lock is high.
- R9: Let L be a nonzero `hold_limit`. If the owner keeps requesting, is unlocked and others are waiting, it is preempted after holding the bus L+1 cycles. The preempted copy pulses `tmo_flag` for one cycle, on the cycle in which its grant drops. L=0 turns the time-out off.
- R10: All copies report the same `owner_id`, and at most one `grant` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all copies |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | ID_W | Index of this agent |
| rotate_mode | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| hold_limit | input | TO_W | Hold limit in cycles; 0 turns the time-out off |
| loc_req | input | 1 | Local agent wants the bus |
| loc_lock | input | 1 | Local agent wants to lock the bus |
| req_drive | output | 1 | Drives this agent's shared request line |
| lock_drive | output | 1 | Drives this agent's share of the lock line |
| req_lines | input | N_AGENTS | All shared request lines, bit i belongs to agent i |
| lock_line | input | 1 | OR of all lock drives |
| grant | output | 1 | This agent owns the bus |
| owner_id | output | ID_W | Current owner as seen by this copy |
| tmo_flag | output | 1 | One-cycle pulse when this agent is preempted by the time-out |

## Verification
Every result is registered once. A change on the request lines or the lock line that is sampled at edge k shows up on `grant`, `owner_id` and `tmo_flag` right after edge k. A time-out preemption lands L+1 edges after the grant was given, counting only unlocked cycles. The bench drives inputs on the falling edge and advances a behavioural model at each rising edge, using only the inputs and the model's own previous owner to work out the lock. It then compares all four copies 1 ns after that edge. This means every expected value is taken in the cycle the design is due to produce it.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HELD  = 2'd1,
        ST_PARK  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/sba_pick.sv
// Priority search over the candidate lines. In fixed mode index 0 wins.
// In rotating mode the search starts one index above last_id and wraps.
// The index arithmetic wraps naturally because N is a power of two.
module sba_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic          rotate,
    input  logic [IW-1:0] last_id,
    output logic          found,
    output logic [IW-1:0] win
);

    always_comb begin
        logic [IW-1:0] idx;
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            idx = rotate ? (last_id + IW'(1) + IW'(k)) : IW'(k);
            if (!found && cand[idx]) begin
                found = 1'b1;
                win   = idx;
            end
        end
    end

endmodule

// File: rtl/sba_hold_timer.sv
// Counts how long the current owner has held the bus. The count saturates
// at its maximum value.
module sba_hold_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (limit != '0) && (cnt_q >= limit);

    // R9: a counter at its ceiling stays there unless it is cleared
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !clr) |=> (cnt_q == '1));

    // R8: while counting is held off, the count does not move
    a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/sba_ctrl.sv
// Ownership state machine. Every copy runs the same machine on the same
// shared inputs; only my_id differs between copies.
module sba_ctrl
    import sba_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] my_id,
    input  logic          rotate,
    input  logic [N-1:0]  req_lines,
    input  logic          lock_line,
    input  logic          expired,
    output logic          timer_clr,
    output logic          timer_en,
    output logic          grant,
    output logic [IW-1:0] owner_id,
    output logic          tmo_flag
);

    localparam logic [N-1:0] ONE_AT0 = {{(N-1){1'b0}}, 1'b1};

    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [IW-1:0] last_q, last_d;
    logic          grant_q, tmo_q;
    logic          held, own_req, hand, tmo_hit;
    logic [N-1:0]  others, cand;
    logic [IW-1:0] start_id, win;
    logic          found;

    assign held     = (state_q == ST_HELD);
    assign own_req  = req_lines[owner_q];
    assign others   = req_lines & ~(ONE_AT0 << owner_q);
    assign cand     = held ? others : req_lines;
    assign start_id = held ? owner_q : last_q;

    sba_pick #(.N(N), .IW(IW)) u_pick (
        .cand    (cand),
        .rotate  (rotate),
        .last_id (start_id),
        .found   (found),
        .win     (win)
    );

    // Next-state and transition selection
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        hand    = 1'b0;
        tmo_hit = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (found) begin            // claim
                    state_d = ST_HELD;
                    owner_d = win;
                end
            end
            ST_HELD: begin
                if (!lock_line) begin       // otherwise: lock hold
                    if (!own_req) begin
                        last_d = owner_q;
                        if (found) begin    // release handover
                            owner_d = win;
                            hand    = 1'b1;
                        end else begin      // park
                            state_d = ST_PARK;
                        end
                    end else if (expired && found) begin  // timeout handover
                        last_d  = owner_q;
                        owner_d = win;
                        hand    = 1'b1;
                        tmo_hit = 1'b1;
                    end
                end
            end
            ST_PARK: begin
                if (!lock_line && found) begin   // claim
                    state_d = ST_HELD;
                    owner_d = win;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign timer_clr = !held || hand;
    assign timer_en  = !lock_line;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            owner_q <= '0;
            last_q  <= '1;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            grant_q <= (state_d != ST_EMPTY) && (owner_d == my_id);
            tmo_q   <= tmo_hit && (owner_q == my_id);
        end
    end

    assign grant    = grant_q;
    assign owner_id = owner_q;
    assign tmo_flag = tmo_q;

    // R1: a grant exists only once an owner has been chosen
    a_r1_grant_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> (state_q != ST_EMPTY));

    // R5: a requesting owner below its limit is not displaced
    a_r5_keep_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        (held && own_req && !expired) |=> $stable(owner_q));

    // R6: an unlocked owner that drops its request either parks or hands over
    a_r6_release_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !lock_line && !own_req) |=>
            (state_q == ST_PARK || owner_q != $past(owner_q)));

    // R7: a parked bus with no requests stays with its owner
    a_r7_park_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && req_lines == '0) |=>
            (state_q == ST_PARK && $stable(owner_q) && $stable(grant_q)));

    // R8: the lock freezes ownership
    a_r8_lock_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_line && state_q != ST_EMPTY) |=> $stable(owner_q));

    // R9: the time-out pulse marks the edge where this copy lost its grant
    a_r9_tmo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> ($past(grant_q) && !grant_q));

endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter #(
    parameter int N_AGENTS = 4,
    parameter int TO_W     = 8,
    localparam int ID_W    = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     my_id,
    input  logic                rotate_mode,
    input  logic [TO_W-1:0]     hold_limit,
    input  logic                loc_req,
    input  logic                loc_lock,
    output logic                req_drive,
    output logic                lock_drive,
    input  logic [N_AGENTS-1:0] req_lines,
    input  logic                lock_line,
    output logic                grant,
    output logic [ID_W-1:0]     owner_id,
    output logic                tmo_flag
);

    logic timer_clr, timer_en, expired;

    sba_hold_timer #(.TW(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (timer_clr),
        .en      (timer_en),
        .limit   (hold_limit),
        .expired (expired)
    );

    sba_ctrl #(.N(N_AGENTS), .IW(ID_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .my_id     (my_id),
        .rotate    (rotate_mode),
        .req_lines (req_lines),
        .lock_line (lock_line),
        .expired   (expired),
        .timer_clr (timer_clr),
        .timer_en  (timer_en),
        .grant     (grant),
        .owner_id  (owner_id),
        .tmo_flag  (tmo_flag)
    );

    assign req_drive  = loc_req;
    assign lock_drive = loc_lock && grant;

    // R2: only the grant holder can raise the shared lock
    a_r2_lock_only_owner: assert property (@(posedge clk) disable iff (!rst_n)
        lock_drive |-> grant);

endmodule

// File: tb/shared_bus_arbiter_tb.sv
`timescale 1ns/1ps
module shared_bus_arbiter_tb;

    localparam int NA = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    bit [NA-1:0] rq = '0;
    bit [NA-1:0] lk = '0;
    bit          rot = 1'b0;
    bit [7:0]    lim = 8'd0;

    logic [NA-1:0] req_drive, lock_drive, grant, tmo;
    logic [1:0]    own [NA];
    logic          lock_line;
    assign lock_line = |lock_drive;

    for (genvar i = 0; i < NA; i++) begin : g_ag
        shared_bus_arbiter u_dut (
            .clk         (clk),
            .rst_n       (rst_n),
            .my_id       (2'(i)),
            .rotate_mode (rot),
            .hold_limit  (lim),
            .loc_req     (rq[i]),
            .loc_lock    (lk[i]),
            .req_drive   (req_drive[i]),
            .lock_drive  (lock_drive[i]),
            .req_lines   (req_drive),
            .lock_line   (lock_line),
            .grant       (grant[i]),
            .owner_id    (own[i]),
            .tmo_flag    (tmo[i])
        );
    end

    int    n_tests = 0;
    int    n_fail  = 0;
    string tag     = "R1";
    bit    done    = 1'b0;

    // Behavioural reference: 0 none, 1 held, 2 parked
    int          m_state = 0;
    int          m_owner = 0;
    int          m_last  = NA - 1;
    int          m_cnt   = 0;
    bit [NA-1:0] m_tmo   = '0;

    function automatic int pick(bit [NA-1:0] c, bit r, int start);
        for (int k = 0; k < NA; k++) begin
            int i;
            i = r ? (start + 1 + k) % NA : k;
            if (c[i]) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        int st0, own0, w;
        bit lkb, hand, exp_;
        bit [NA-1:0] oth;
        bit [NA-1:0] eg, elk;
        if (!rst_n) begin
            m_state = 0; m_owner = 0; m_last = NA - 1; m_cnt = 0; m_tmo = '0;
        end else begin
            st0  = m_state;
            own0 = m_owner;
            lkb  = (st0 != 0) && lk[own0];
            oth  = rq & ~(NA'(1) << own0);
            exp_ = (lim != 0) && (m_cnt >= int'(lim));
            hand = 1'b0;
            m_tmo = '0;
            case (st0)
                0: begin
                    w = pick(rq, rot, m_last);
                    if (w >= 0) begin m_state = 1; m_owner = w; end
                end
                1: if (!lkb) begin
                    if (!rq[own0]) begin
                        m_last = own0;
                        w = pick(oth, rot, own0);
                        if (w >= 0) begin m_owner = w; hand = 1'b1; end
                        else m_state = 2;
                    end else if (exp_) begin
                        w = pick(oth, rot, own0);
                        if (w >= 0) begin
                            m_last = own0; m_owner = w; hand = 1'b1; m_tmo[own0] = 1'b1;
                        end
                    end
                end
                default: if (!lkb) begin
                    w = pick(rq, rot, m_last);
                    if (w >= 0) begin m_state = 1; m_owner = w; end
                end
            endcase
            if (st0 != 1 || hand) m_cnt = 0;
            else if (!lkb && m_cnt < 255) m_cnt++;
        end
        #1;
        if (rst_n && !done) begin
            eg  = (m_state != 0) ? (NA'(1) << m_owner) : '0;
            elk = lk & eg;
            n_tests++;
            if (grant !== eg || tmo !== m_tmo) begin
                n_fail++;
                $display("FAIL %s grant=%b tmo=%b expected grant=%b tmo=%b", tag, grant, tmo, eg, m_tmo);
            end
            for (int i = 0; i < NA; i++) begin
                if (own[i] !== 2'(m_owner)) begin  // R10 agreement
                    n_fail++;
                    $display("FAIL R10 copy %0d owner=%0d expected %0d", i, own[i], m_owner);
                end
            end
            if ($countones(grant) > 1) begin       // R10 single grant
                n_fail++;
                $display("FAIL R10 grants=%b expected at most one", grant);
            end
            n_tests++;                             // R2 line drives
            if (req_drive !== rq || lock_drive !== elk) begin
                n_fail++;
                $display("FAIL R2 req=%b lock=%b expected req=%b lock=%b", req_drive, lock_drive, rq, elk);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        cyc(3);
        n_tests++;
        if (grant !== '0 || tmo !== '0 || own[0] !== 2'd0) begin
            n_fail++;
            $display("FAIL R1 grant=%b tmo=%b owner=%0d expected 0 0 0", grant, tmo, own[0]);
        end
        rst_n = 1'b1;
        cyc(2);
        tag = "R3"; rq = 4'b1010; cyc(3);          // fixed: agent 1 wins
        tag = "R7"; rq = 4'b0000; cyc(4);          // parking
        tag = "R3"; rq = 4'b1100; cyc(3);          // agent 2
        tag = "R6"; rq = 4'b1001; cyc(3);          // handover to 0
        tag = "R6"; rq = 4'b1000; cyc(3);          // handover to 3
        tag = "R5"; rq = 4'b1111; cyc(6);          // no limit: owner stays
        tag = "R9"; lim = 8'd3; cyc(12);           // fixed time-out
        tag = "R4"; rot = 1'b1; cyc(20);           // rotating time-out
        tag = "R4"; lim = 8'd0; rq = 4'b0000; cyc(3);
        rq = 4'b1111; cyc(2);
        rq = 4'b0000; cyc(2);
        rq = 4'b1011; cyc(3);
        tag = "R8"; lim = 8'd2; lk = 4'b1111; rq = 4'b1111; cyc(10);
        tag = "R8"; rq = 4'b0101; cyc(4);
        lk = 4'b0000; cyc(6);
        tag = "R10";
        for (int s = 0; s < 6; s++) begin
            rot = s[0];
            lim = 8'($urandom_range(0, 5));
            for (int c = 0; c < 80; c++) begin
                rq = 4'($urandom);
                lk = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0000;
                cyc(1);
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        done = 1'b1;
        $display("FAIL watchdog expired, run did not end");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule